// File: doc/BRIEF.md
# Daisy-Chained Vectored Interrupt Unit

This block lets several devices share one active-high interrupt-request line to a processor and hands back the vector of the device being served. Each device has a stage that holds a pending flag and sees that device's 16-bit vector code. A one-cycle pulse on `req_set[i]` marks device i pending. The shared request line `irq` is high while any stage is pending.

When the processor is ready for a vector, it pulses `ack` for one cycle. The acknowledge enters stage 0, which is nearest the processor. A stage with nothing pending passes it to the next stage. The first pending stage keeps it. That stage puts its vector onto the internal bus and clears its pending flag. All other stages drive zero. The bus value is registered, so the vector appears on `vec_out` with `vec_valid` in the cycle after the acknowledge is sampled. In that same cycle it is also split into a service-routine index and a new processor status value.

Top module: `irq_chain_top`

## Requirements
- R1: After synchronous reset, no device is pending. `irq`, `vec_valid`, `vec_out`, `isr_idx`, `new_psw` and `grant_q` are all zero.
- R2: A pulse on `req_set[i]` makes device i pending from the next clock edge. `irq` is high whenever at least one device is pending.
- R3: When `ack` is sampled high, the pending device with the lowest index wins. `grant_q` shows that device as one-hot in the next cycle. `grant_q` is zero in every cycle that does not directly follow a sampled `ack`.
- R4: In the cycle after `ack` is sampled with a winner, `vec_valid` is 1. `vec_out` equals the winner's 16-bit slice of `vec_cfg` (bits 16*i+15 down to 16*i) as it was at that clock edge. `vec_valid` lasts exactly that one cycle.
- R5: The winning device's pending flag is cleared by the acknowledge. Every other pending device stays pending and wins a later acknowledge in index order.
- R6: If `ack` is sampled with no device pending, nothing is granted. `vec_valid` stays 0 and `vec_out` stays zero. `vec_out` is zero in every cycle where `vec_valid` is 0.
- R7: A request that is raised in the same cycle that `ack` is sampled does not take part in that acknowledge. It is pending afterwards and can win the next acknowledge.
- R8: `isr_idx` equals `vec_out[15:8]` (the service-routine index) and `new_psw` equals `vec_out[7:0]` (the new status value).
- R9: At most one device is granted per acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_set | input | N_DEV | Per-device request pulse that sets the pending flag |
| vec_cfg | input | 16*N_DEV | Per-device vector codes; device i uses bits 16*i+15 down to 16*i |
| ack | input | 1 | One-cycle interrupt acknowledge from the processor |
| irq | output | 1 | Shared interrupt request, high while any device is pending |
| vec_valid | output | 1 | High for the one cycle in which the granted vector is on `vec_out` |
| vec_out | output | 16 | Granted vector, zero when nothing is granted |
| isr_idx | output | 8 | Service-routine index field of the granted vector |
| new_psw | output | 8 | Processor status field of the granted vector |
| grant_q | output | N_DEV | One-hot identity of the device granted by the previous acknowledge |

## Verification
The assertions assume that `ack` is high for only one cycle at a time, as the processor handshake requires. They also assume that `vec_cfg` is stable in the cycle `ack` is sampled. The bench drives every input at the falling edge. It raises `ack` for exactly one cycle and then holds it low while it samples the result. It loads vector codes once, before the first acknowledge. Request pulses are also one cycle long, and they are combined with `ack` only in the deliberate same-cycle case of R7.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;

    localparam int VEC_W   = 16;
    localparam int FIELD_W = VEC_W / 2;

    // Vector layout: upper half selects the service routine, lower half is
    // the status word loaded on entry.
    typedef struct packed {
        logic [FIELD_W-1:0] isr_idx;
        logic [FIELD_W-1:0] psw;
    } vec_t;

    function automatic vec_t vec_gate(input vec_t v, input logic en);
        return en ? v : '0;
    endfunction

endpackage

// File: rtl/irq_chain_stage.sv
module irq_chain_stage
    import irq_chain_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_set,
    input  logic ack_in,
    input  vec_t vec_code,
    output logic ack_out,
    output logic grant,
    output logic pending,
    output vec_t vec_drive
);

    logic pend_q;

    // A stage keeps the acknowledge if it is pending, otherwise forwards it.
    assign grant     = ack_in & pend_q;
    assign ack_out   = ack_in & ~pend_q;
    assign pending   = pend_q;
    assign vec_drive = vec_gate(vec_code, grant);

    // A new request landing on the grant edge survives the clear.
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= (pend_q & ~grant) | req_set;
        end
    end

endmodule

// File: rtl/irq_vec_merge.sv
module irq_vec_merge
    import irq_chain_pkg::*;
#(
    parameter int N_DEV = 4
) (
    input  vec_t drv [N_DEV],
    output vec_t merged
);

    // Wired-OR bus: every non-granted stage drives zero.
    always_comb begin
        merged = '0;
        for (int i = 0; i < N_DEV; i++) begin
            merged = merged | drv[i];
        end
    end

endmodule

// File: rtl/irq_chain_top.sv
module irq_chain_top
    import irq_chain_pkg::*;
#(
    parameter int N_DEV = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N_DEV-1:0]       req_set,
    input  logic [N_DEV*VEC_W-1:0] vec_cfg,
    input  logic                   ack,
    output logic                   irq,
    output logic                   vec_valid,
    output logic [VEC_W-1:0]       vec_out,
    output logic [FIELD_W-1:0]     isr_idx,
    output logic [FIELD_W-1:0]     new_psw,
    output logic [N_DEV-1:0]       grant_q
);

    logic [N_DEV:0]   ack_c;
    logic [N_DEV-1:0] pend;
    logic [N_DEV-1:0] gnt;
    vec_t             drv [N_DEV];
    vec_t             bus;
    vec_t             vec_q;
    logic             valid_q;
    logic             ack_tail;

    assign ack_c[0] = ack;
    assign ack_tail = ack_c[N_DEV];

    for (genvar g = 0; g < N_DEV; g++) begin : g_stage
        irq_chain_stage u_stage (
            .clk       (clk),
            .rst       (rst),
            .req_set   (req_set[g]),
            .ack_in    (ack_c[g]),
            .vec_code  (vec_t'(vec_cfg[g*VEC_W +: VEC_W])),
            .ack_out   (ack_c[g+1]),
            .grant     (gnt[g]),
            .pending   (pend[g]),
            .vec_drive (drv[g])
        );
    end

    irq_vec_merge #(.N_DEV(N_DEV)) u_merge (
        .drv    (drv),
        .merged (bus)
    );

    assign irq = |pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q   <= '0;
            valid_q <= 1'b0;
            grant_q <= '0;
        end else begin
            vec_q   <= bus;
            valid_q <= |gnt;
            grant_q <= gnt;
        end
    end

    assign vec_valid = valid_q;
    assign vec_out   = vec_q;
    assign isr_idx   = vec_q.isr_idx;
    assign new_psw   = vec_q.psw;

endmodule

// File: rtl/irq_chain_chk.sv
module irq_chain_chk #(
    parameter int N_DEV = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             ack,
    input logic             ack_tail,
    input logic [N_DEV-1:0] req_set,
    input logic             irq,
    input logic             vec_valid,
    input logic [15:0]      vec_out,
    input logic [N_DEV-1:0] grant_q
);

    // R9: never more than one winner
    a_r9_single_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_q));

    // R6: bus reads zero whenever no vector is presented
    a_r6_idle_bus_zero: assert property (@(posedge clk) disable iff (rst)
        !vec_valid |-> (vec_out == '0));

    // R6: acknowledge that fell off the end of the chain grants nobody
    a_r6_unclaimed_ack: assert property (@(posedge clk) disable iff (rst)
        ack_tail |=> !vec_valid);

    // R4: a vector only follows a sampled acknowledge
    a_r4_valid_after_ack: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> $past(ack));

    // R2: any request raises the shared line on the next cycle
    a_r2_req_raises_irq: assert property (@(posedge clk) disable iff (rst)
        (|req_set) |=> irq);

    // R3: grant identity agrees with the valid flag
    a_r3_grant_matches_valid: assert property (@(posedge clk) disable iff (rst)
        vec_valid == (grant_q != '0));

endmodule

bind irq_chain_top irq_chain_chk #(.N_DEV(N_DEV)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ack       (ack),
    .ack_tail  (ack_tail),
    .req_set   (req_set),
    .irq       (irq),
    .vec_valid (vec_valid),
    .vec_out   (vec_out),
    .grant_q   (grant_q)
);

// File: tb/tb_irq_chain_top.sv
module tb_irq_chain_top;

    localparam int N = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N-1:0]    req_set = '0;
    logic [N*16-1:0] vec_cfg = '0;
    logic            ack = 1'b0;
    logic            irq;
    logic            vec_valid;
    logic [15:0]     vec_out;
    logic [7:0]      isr_idx;
    logic [7:0]      new_psw;
    logic [N-1:0]    grant_q;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    irq_chain_top #(.N_DEV(N)) dut (
        .clk(clk), .rst(rst), .req_set(req_set), .vec_cfg(vec_cfg),
        .ack(ack), .irq(irq), .vec_valid(vec_valid), .vec_out(vec_out),
        .isr_idx(isr_idx), .new_psw(new_psw), .grant_q(grant_q)
    );

    // {request mask, first winner, second winner}
    localparam logic [11:0] TBL [7] = '{
        {4'b0001, 4'b0001, 4'b0000},
        {4'b1010, 4'b0010, 4'b1000},
        {4'b1100, 4'b0100, 4'b1000},
        {4'b1111, 4'b0001, 4'b0010},
        {4'b1000, 4'b1000, 4'b0000},
        {4'b0000, 4'b0000, 4'b0000},
        {4'b0110, 4'b0010, 4'b0100}
    };

    function automatic logic [15:0] vec_of(input int i);
        return {8'(8'h40 + i * 4), 8'(8'hC0 | i)};
    endfunction

    function automatic logic [15:0] vec_for(input logic [N-1:0] oh);
        logic [15:0] v = '0;
        for (int i = 0; i < N; i++) if (oh[i]) v = vec_of(i);
        return v;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; req_set = '0; ack = 1'b0;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic pulse_req(input logic [N-1:0] m);
        @(negedge clk); req_set = m;
        @(negedge clk); req_set = '0;
    endtask

    // After return, the sampled cycle following the acknowledge is current.
    task automatic pulse_ack(input logic [N-1:0] also_req);
        @(negedge clk); ack = 1'b1; req_set = also_req;
        @(negedge clk); ack = 1'b0; req_set = '0;
    endtask

    task automatic expect_grant(input logic [N-1:0] win, input string tag);
        logic [15:0] ev = vec_for(win);
        check(grant_q == win, {tag, " R3 grant"}, 32'(grant_q), 32'(win));
        check(vec_valid == (win != '0), {tag, " R4/R6 valid"}, 32'(vec_valid), 32'(win != '0));
        check(vec_out == ev, {tag, " R4/R6 vector"}, 32'(vec_out), 32'(ev));
        check(isr_idx == ev[15:8] && new_psw == ev[7:0], {tag, " R8 fields"},
              {16'h0, isr_idx, new_psw}, 32'(ev));
    endtask

    initial begin
        for (int i = 0; i < N; i++) vec_cfg[i*16 +: 16] = vec_of(i);
        do_reset();
        // R1: reset state
        check(irq == 1'b0 && vec_valid == 1'b0 && grant_q == '0,
              "R1 reset flags", {29'h0, irq, vec_valid, |grant_q}, 32'h0);
        check(vec_out == '0 && isr_idx == '0 && new_psw == '0,
              "R1 reset vector", 32'(vec_out), 32'h0);

        foreach (TBL[k]) begin
            logic [N-1:0] m  = TBL[k][11:8];
            logic [N-1:0] w1 = TBL[k][7:4];
            logic [N-1:0] w2 = TBL[k][3:0];
            do_reset();
            pulse_req(m);
            check(irq == (m != '0), "R2 irq after request", 32'(irq), 32'(m != '0));
            pulse_ack('0);
            expect_grant(w1, "first");
            check(irq == ((m & ~w1) != '0), "R5 remaining irq", 32'(irq),
                  32'((m & ~w1) != '0));
            @(negedge clk);
            check(vec_valid == 1'b0 && grant_q == '0, "R4 one-cycle valid",
                  32'(vec_valid), 32'h0);
            pulse_ack('0);
            expect_grant(w2, "second R5");
        end

        // R7: request raised with acknowledge, another device already pending
        do_reset();
        pulse_req(4'b0100);
        pulse_ack(4'b0001);
        expect_grant(4'b0100, "R7 lower index late");
        check(irq == 1'b1, "R7 late request pending", 32'(irq), 32'h1);
        pulse_ack('0);
        expect_grant(4'b0001, "R7 late request next ack");

        // R7 / R6: request raised with acknowledge on an empty chain
        do_reset();
        pulse_ack(4'b0010);
        expect_grant('0, "R7 empty chain");
        check(irq == 1'b1, "R7 pending after empty ack", 32'(irq), 32'h1);
        pulse_ack('0);
        expect_grant(4'b0010, "R7 granted later");
        check(irq == 1'b0, "R5 chain drained", 32'(irq), 32'h0);

        // R9: full chain drains one device per acknowledge, lowest index first
        do_reset();
        pulse_req(4'b1111);
        for (int i = 0; i < N; i++) begin
            pulse_ack('0);
            check($countones(grant_q) == 1 && grant_q[i], "R9 single ordered grant",
                  32'(grant_q), 32'(1 << i));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule